// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block sits in a DRAM controller next to the command arbiter. It keeps time for periodic auto refresh. The memory has to refresh all 4096 rows every 32 ms, which works out to one refresh command about every 7.8 µs. Software sets the number of controller clock cycles in one interval (1560 cycles at 200 MHz). Each time an interval expires, the block adds one to its count of owed refreshes and asks the arbiter for a refresh. The arbiter closes any open banks, issues the refresh command and acknowledges with a grant. The memory supplies the row address from its own counter, so this block never produces one.

The block also controls the clock-enable line. When the system requests self refresh, the block waits until the arbiter reports that all banks are idle. It then lowers the clock-enable line on the same cycle that it signals the refresh command to issue. While the memory refreshes itself, the block forgives all owed refreshes and stops timing intervals. When the request is withdrawn, it raises the clock-enable line and holds a window in which only no-operation commands may be issued. It then restarts interval timing from a full interval.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cke` is 1 and `owed_count`, `ref_req`, `ref_urgent`, `sr_cmd` and `nop_only` are all 0.
- R2: In normal operation `owed_count` rises by one every `interval_cycles` clock edges. The first rise comes on the `interval_cycles`-th rising edge after reset is released.
- R3: `owed_count` never exceeds 8. At 8 it holds instead of wrapping. `ref_urgent` is 1 exactly when `owed_count` equals 8.
- R4: In normal operation `ref_req` is 1 whenever `owed_count` is non-zero. A sampled `ref_gnt` lowers the count by one. A grant while the count is 0 has no effect. A grant on the same edge as an interval expiry leaves the count unchanged.
- R5: A self-refresh request does not lower `cke` until `banks_idle` is seen high together with the request. While the request waits, `ref_req` is 0. If the request is withdrawn before the banks are idle, normal operation resumes and `cke` never drops.
- R6: After a clock edge that samples `sr_req` and `banks_idle` both high while waiting, `cke` is 0 and `sr_cmd` is 1 for exactly that one cycle, and `owed_count` is 0.
- R7: During self refresh, `cke` stays 0, `ref_req` stays 0, `owed_count` stays 0, `ref_gnt` is ignored and intervals are not counted.
- R8: After an edge that samples `sr_req` low during self refresh, `cke` is 1 and `nop_only` is 1 for max(`exit_nop_cycles`, 1) cycles, then falls to 0.
- R9: After `nop_only` falls, the next increment of `owed_count` comes a full `interval_cycles` edges later.
- R10: `cke` only falls in a cycle where `sr_cmd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| interval_cycles | input | 16 | Clock cycles per refresh interval |
| exit_nop_cycles | input | 8 | Length of the NOP-only window after self-refresh exit |
| sr_req | input | 1 | Level request to stay in self refresh |
| banks_idle | input | 1 | Arbiter acknowledgement that all banks are precharged |
| ref_gnt | input | 1 | Arbiter has issued one auto refresh this cycle |
| ref_req | output | 1 | Request for an auto refresh |
| ref_urgent | output | 1 | Owed count has reached its ceiling |
| sr_cmd | output | 1 | Issue the refresh command now (self-refresh entry) |
| cke | output | 1 | Clock enable to the memory |
| nop_only | output | 1 | Only NOP commands are allowed this cycle |
| owed_count | output | 4 | Number of owed refreshes |

## Verification
The hardest situations to reach are an interval expiry on the same edge as a grant while the count is saturated, and a grant while the count is empty. The stimulus first lets the count climb to the ceiling with a short interval. It then holds grants through a long stretch so that they straddle expiries and keep arriving after the count reaches zero. The self-refresh path is driven through a withdrawn request, a full entry with grants that toggle during self refresh, and exits with both a multi-cycle NOP window and a zero setting. A behavioural model is compared on every cycle.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_WAIT = 2'd1,
      PS_SELF = 2'd2,
      PS_EXIT = 2'd3
   } pwr_state_t;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] interval,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("rfs_interval_timer: CNT_W must be at least 2");
      end
   endgenerate

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign tick    = run && (cnt_inc >= {1'b0, interval});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_inc[CNT_W-1:0];
   end
endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
   parameter int OWED_MAX = 8,
   localparam int OWED_W = $clog2(OWED_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic              clr,
   output logic [OWED_W-1:0] owed,
   output logic              full
);
   logic dec_eff;

   generate
      if (OWED_MAX < 1) begin : g_bad_max
         $error("rfs_owed_counter: OWED_MAX must be at least 1");
      end
      if (OWED_MAX == (1 << OWED_W) - 1) begin : g_full_allones
         assign full = &owed;
      end else begin : g_full_cmp
         assign full = (owed == OWED_W'(OWED_MAX));
      end
   endgenerate

   assign dec_eff = dec && (owed != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owed <= '0;
      else if (clr)
         owed <= '0;
      else if (inc && !dec_eff && !full)
         owed <= owed + 1'b1;
      else if (!inc && dec_eff)
         owed <= owed - 1'b1;
   end

   AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      owed <= OWED_W'(OWED_MAX)); // R3
   AST_OWED_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (owed == OWED_W'(OWED_MAX) && !dec && !clr) |=> owed == OWED_W'(OWED_MAX)); // R3
   AST_GNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (owed == '0 && !inc && !clr) |=> owed == '0); // R4
endmodule

// File: rtl/rfs_power_fsm.sv
module rfs_power_fsm
   import refresh_sched_pkg::*;
#(
   parameter int EXIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_req,
   input  logic              banks_idle,
   input  logic [EXIT_W-1:0] exit_cfg,
   output pwr_state_t        state,
   output logic              enter,
   output logic              sr_cmd
);
   pwr_state_t        state_d;
   logic [EXIT_W-1:0] exit_q, exit_d;

   generate
      if (EXIT_W < 1) begin : g_bad_exit
         $error("rfs_power_fsm: EXIT_W must be at least 1");
      end
   endgenerate

   assign enter = (state == PS_WAIT) && sr_req && banks_idle;

   always_comb begin
      state_d = state;
      exit_d  = exit_q;
      unique case (state)
         PS_RUN:  if (sr_req) state_d = PS_WAIT;
         PS_WAIT: begin
            if (!sr_req)        state_d = PS_RUN;
            else if (banks_idle) state_d = PS_SELF;
         end
         PS_SELF: if (!sr_req) begin
            state_d = PS_EXIT;
            exit_d  = exit_cfg;
         end
         PS_EXIT: begin
            if (exit_q <= EXIT_W'(1)) state_d = PS_RUN;
            else                      exit_d  = exit_q - 1'b1;
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PS_RUN;
         exit_q <= '0;
         sr_cmd <= 1'b0;
      end else begin
         state  <= state_d;
         exit_q <= exit_d;
         sr_cmd <= enter;
      end
   end

   AST_ENTRY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_cmd) |-> $past(banks_idle) && $past(sr_req)); // R5
   AST_SELF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_SELF && sr_req) |=> state == PS_SELF); // R7
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refresh_sched_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int OWED_MAX = 8,
   parameter int EXIT_W   = 8,
   localparam int OWED_W  = $clog2(OWED_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  interval_cycles,
   input  logic [EXIT_W-1:0] exit_nop_cycles,
   input  logic              sr_req,
   input  logic              banks_idle,
   input  logic              ref_gnt,
   output logic              ref_req,
   output logic              ref_urgent,
   output logic              sr_cmd,
   output logic              cke,
   output logic              nop_only,
   output logic [OWED_W-1:0] owed_count
);
   pwr_state_t state;
   logic       enter;
   logic       run;
   logic       tick;

   assign run = (state == PS_RUN) || (state == PS_WAIT);

   rfs_power_fsm #(.EXIT_W(EXIT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sr_req     (sr_req),
      .banks_idle (banks_idle),
      .exit_cfg   (exit_nop_cycles),
      .state      (state),
      .enter      (enter),
      .sr_cmd     (sr_cmd)
   );

   rfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .interval (interval_cycles),
      .tick     (tick)
   );

   rfs_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick),
      .dec   (ref_gnt),
      .clr   (enter),
      .owed  (owed_count),
      .full  (ref_urgent)
   );

   assign cke      = (state != PS_SELF);
   assign nop_only = (state == PS_EXIT);
   assign ref_req  = (state == PS_RUN) && (owed_count != '0);

   AST_CKE_FALL_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> sr_cmd); // R10
   AST_LOW_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> !ref_req && owed_count == '0); // R7
   AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> nop_only); // R8
   AST_NOP_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      nop_only |-> cke && !ref_req); // R8
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
   localparam int I = 10;
   localparam int MAXO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] interval_cycles = 16'(I);
   logic [7:0]  exit_nop_cycles = 8'd3;
   logic        sr_req = 1'b0, banks_idle = 1'b0, ref_gnt = 1'b0;
   logic        ref_req, ref_urgent, sr_cmd, cke, nop_only;
   logic [3:0]  owed_count;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;

   refresh_sched i_refresh_sched (
      .clk(clk), .rst_n(rst_n), .interval_cycles(interval_cycles),
      .exit_nop_cycles(exit_nop_cycles), .sr_req(sr_req), .banks_idle(banks_idle),
      .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent), .sr_cmd(sr_cmd),
      .cke(cke), .nop_only(nop_only), .owed_count(owed_count));

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model: mode 0 normal, 1 waiting, 2 self, 3 exit window
   int m_mode = 0, m_t = 0, m_owed = 0, m_x = 0, m_cmd = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_t = 0; m_owed = 0; m_x = 0; m_cmd = 0;
      end else begin
         int counting, expire, go_self, nxt;
         counting = (m_mode <= 1);
         expire   = counting && (m_t + 1 >= int'(interval_cycles));
         go_self  = (m_mode == 1) && sr_req && banks_idle;
         if (go_self || m_mode == 2) nxt = 0;
         else begin
            nxt = m_owed + expire - ((ref_gnt && m_owed > 0) ? 1 : 0);
            if (nxt > MAXO) nxt = MAXO;
         end
         m_owed = nxt;
         m_t = (!counting || expire) ? 0 : m_t + 1;
         m_cmd = go_self;
         case (m_mode)
            0: if (sr_req) m_mode = 1;
            1: if (!sr_req) m_mode = 0; else if (banks_idle) m_mode = 2;
            2: if (!sr_req) begin m_mode = 3; m_x = int'(exit_nop_cycles); end
            default: if (m_x <= 1) m_mode = 0; else m_x = m_x - 1;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(owed_count == 4'(m_owed), "R2 owed_count", owed_count, m_owed);
         chk(ref_urgent == (m_owed == MAXO), "R3 ref_urgent", ref_urgent, m_owed == MAXO);
         chk(ref_req == (m_mode == 0 && m_owed != 0), "R4 ref_req", ref_req, m_mode == 0 && m_owed != 0);
         chk(cke == (m_mode != 2), "R6 cke", cke, m_mode != 2);
         chk(sr_cmd == m_cmd[0], "R6 sr_cmd", sr_cmd, m_cmd);
         chk(nop_only == (m_mode == 3), "R8 nop_only", nop_only, m_mode == 3);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_mark;
      #2;
   endtask

   task automatic exit_and_count(int exp_nops);
      int n = 0;
      drive_mark(); sr_req = 1'b0;
      @(negedge clk);
      chk(cke == 1'b1, "R8 cke high on exit", cke, 1);
      while (nop_only && n < 300) begin n++; @(negedge clk); end
      chk(n == exp_nops, "R8 nop window length", n, exp_nops);
      step(I - 1);
      chk(owed_count == 0, "R9 no increment before full interval", owed_count, 0);
      step(1);
      chk(owed_count == 1, "R9 increment after full interval", owed_count, 1);
   endtask

   initial begin
      step(2);
      chk(cke == 1 && owed_count == 0 && !ref_req && !ref_urgent && !sr_cmd && !nop_only,
          "R1 reset state", {cke, owed_count, ref_req, ref_urgent, sr_cmd, nop_only}, 9'b1_0000_0000);
      drive_mark(); rst_n = 1'b1;
      @(negedge clk);
      chk(cke == 1 && owed_count == 0 && !ref_req, "R1 first cycle", owed_count, 0);
      step(I - 2);
      chk(owed_count == 0, "R2 before first interval", owed_count, 0);
      step(1);
      chk(owed_count == 1, "R2 first interval", owed_count, 1);
      step(MAXO * I + 25);
      chk(owed_count == MAXO && ref_urgent, "R3 saturated", owed_count, MAXO);
      // one grant pulse
      drive_mark(); ref_gnt = 1'b1;
      @(negedge clk); drive_mark(); ref_gnt = 1'b0;
      @(negedge clk);
      chk(!ref_urgent && ref_req, "R4 single grant leaves count below ceiling", ref_urgent, 0);
      // long grant stretch: drains, crosses expiries, grants on empty count
      drive_mark(); ref_gnt = 1'b1;
      step(3 * I);
      chk(owed_count <= 1, "R4 grants drain count", owed_count, 0);
      drive_mark(); ref_gnt = 1'b0;
      // self-refresh request without idle banks
      step(1); drive_mark(); sr_req = 1'b1; banks_idle = 1'b0;
      step(6);
      chk(cke == 1 && !ref_req, "R5 waiting for idle", {cke, ref_req}, 2'b10);
      drive_mark(); sr_req = 1'b0;
      step(3);
      chk(cke == 1, "R5 withdrawn request", cke, 1);
      drive_mark(); sr_req = 1'b1;
      step(3);
      drive_mark(); banks_idle = 1'b1;
      @(negedge clk);
      chk(!cke && sr_cmd && owed_count == 0, "R6 entry", {cke, sr_cmd}, 2'b01);
      drive_mark(); banks_idle = 1'b0;
      @(negedge clk);
      chk(!sr_cmd && !cke, "R6 single command cycle", sr_cmd, 0);
      for (int k = 0; k < 4 * I; k++) begin
         drive_mark(); ref_gnt = k[0];
         @(negedge clk);
      end
      drive_mark(); ref_gnt = 1'b0;
      chk(!cke && owed_count == 0 && !ref_req, "R7 quiet during self refresh", owed_count, 0);
      exit_and_count(3);
      // second round with zero exit window
      drive_mark(); exit_nop_cycles = 8'd0; sr_req = 1'b1; banks_idle = 1'b1;
      step(4);
      chk(!cke, "R6 re-entry", cke, 0);
      exit_and_count(1);
      // varied interval and grant pattern
      drive_mark(); interval_cycles = 16'd4; banks_idle = 1'b0;
      for (int k = 0; k < 120; k++) begin
         @(negedge clk); drive_mark(); ref_gnt = (k % 7 == 3) || (k % 5 == 0);
      end
      drive_mark(); ref_gnt = 1'b0;
      step(60);
      chk(owed_count == MAXO, "R3 saturation at short interval", owed_count, MAXO);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule